// File: doc/BRIEF.md
# Sleep Entry and Clock Gating Controller

This block decides when a processor core may stop running and how much of the clock and power tree goes off with it. The core reports two instruction strobes. One asks to wait for an interrupt and always enters sleep. The other asks to wait for an event and enters sleep only when a one-bit pending-event flag is clear. If that flag is set, the flag is consumed and the core carries on. A depth select bit, sampled at the moment of entry, chooses between two depths. The light depth gates only the processor clock. The deep depth also gates the system clock and turns off the PLL and flash enables.

A wakeup request, an event set input or a debug request ends sleep. After deep sleep the enables come back in three stages, one cycle apart. A debug wakeup leaves the event flag untouched, so a spurious wakeup can be followed at once by another wait-for-event that sleeps again. Any wake source that arrives in the same cycle as an entry strobe cancels the entry. A one-cycle resume pulse tells the core when it may continue.

Top module: `sleep_gate_ctrl`

## Requirements
- R1: With no wake source present, a wait-for-interrupt strobe while running drives procClkEn low from the next clock edge.
- R2: A wait-for-event strobe while running and with the event flag clear enters sleep from the next edge. The flag is clear after reset.
- R3: A wait-for-event strobe while the event flag is set does not enter sleep. It clears the flag and raises resumeOut for one cycle, so the next wait-for-event strobe sleeps.
- R4: eventSet and wakeReq each set the event flag. When a set and a wait-for-event consumption fall in the same cycle, the flag stays set.
- R5: Entry with deepSel=0 lowers only procClkEn. sysClkEn, pllEn and flashEn stay high throughout.
- R6: Entry with deepSel=1 lowers procClkEn, sysClkEn, pllEn and flashEn together at the next edge.
- R7: Waking from deep sleep raises pllEn and flashEn at the edge that samples the wake source. sysClkEn rises one cycle later and procClkEn one cycle after that.
- R8: Waking from light sleep raises procClkEn at the edge that samples the wake source.
- R9: sleeping is high exactly when procClkEn is low.
- R10: A wake source (wakeReq, debugReq or eventSet) in the same cycle as an entry strobe cancels the entry. No enable drops and resumeOut pulses.
- R11: A debugReq wakeup does not set the event flag, so a following wait-for-event strobe enters sleep again.
- R12: resumeOut is high for exactly one cycle, the cycle in which procClkEn has just returned high after sleep.
- R13: Entry strobes that arrive while asleep or waking are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rstN | input | 1 | Active-low synchronous reset |
| wfiStrobe | input | 1 | Wait-for-interrupt executed, one cycle |
| wfeStrobe | input | 1 | Wait-for-event executed, one cycle |
| eventSet | input | 1 | Sets the event flag and wakes the core |
| deepSel | input | 1 | Depth select: 1 = deep sleep |
| wakeReq | input | 1 | Wakeup-capable interrupt pending |
| debugReq | input | 1 | Debug request; wakes without setting the flag |
| procClkEn | output | 1 | Processor clock enable |
| sysClkEn | output | 1 | System clock enable |
| pllEn | output | 1 | PLL enable |
| flashEn | output | 1 | Flash enable |
| sleeping | output | 1 | Core is held with its clock gated |
| resumeOut | output | 1 | One-cycle continue indication |

## Verification
A wrong event flag has no output of its own. It shows up at the next wait-for-event strobe, which then either sleeps when it should continue or continues when it should sleep. That difference is visible on procClkEn and resumeOut one edge after the strobe. A wrong sequencer state shows within one cycle as an enable pattern that cannot occur: PLL off while the system clock is on, or a resume pulse while the processor clock is still gated. The bench therefore compares every output on every cycle against a model built from the requirements, and directed runs drive the flag through each of its transitions.

// File: rtl/sleep_gate_pkg.sv
`timescale 1ns/1ps
package sleep_gate_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_SLP_NORM,
    ST_SLP_DEEP,
    ST_WAKE_PF,
    ST_WAKE_SYS
  } gateState_t;

  // strobes from the control FSM to the enable/flag datapath
  typedef struct packed {
    logic gateProc;
    logic gateDeep;
    logic restorePf;
    logic restoreSys;
    logic restoreProc;
    logic evtClear;
    logic resume;
  } gateCtrl_t;

endpackage

// File: rtl/sleep_gate_fsm.sv
`timescale 1ns/1ps
module sleep_gate_fsm
  import sleep_gate_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wfiStrobe,
  input  logic      wfeStrobe,
  input  logic      deepSel,
  input  logic      wakeAny,
  input  logic      evtFlag,
  output gateCtrl_t ctrl
);

  gateState_t state, stateNext;
  logic       enterReq;

  assign enterReq = wfiStrobe || (wfeStrobe && !evtFlag);

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    unique case (state)
      ST_RUN: begin
        if (enterReq && wakeAny) begin
          ctrl.resume = 1'b1;            // entry cancelled
        end else if (enterReq) begin
          if (deepSel) begin
            ctrl.gateDeep = 1'b1;
            stateNext     = ST_SLP_DEEP;
          end else begin
            ctrl.gateProc = 1'b1;
            stateNext     = ST_SLP_NORM;
          end
        end else if (wfeStrobe && evtFlag) begin
          ctrl.evtClear = 1'b1;
          ctrl.resume   = 1'b1;
        end
      end
      ST_SLP_NORM: begin
        if (wakeAny) begin
          ctrl.restoreProc = 1'b1;
          ctrl.resume      = 1'b1;
          stateNext        = ST_RUN;
        end
      end
      ST_SLP_DEEP: begin
        if (wakeAny) begin
          ctrl.restorePf = 1'b1;
          stateNext      = ST_WAKE_PF;
        end
      end
      ST_WAKE_PF: begin
        ctrl.restoreSys = 1'b1;
        stateNext       = ST_WAKE_SYS;
      end
      ST_WAKE_SYS: begin
        ctrl.restoreProc = 1'b1;
        ctrl.resume      = 1'b1;
        stateNext        = ST_RUN;
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

  AST_WFI_ENTERS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && wfiStrobe && !wakeAny) |=> (state == ST_SLP_NORM || state == ST_SLP_DEEP)); // R1
  AST_ABORT_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && (wfiStrobe || wfeStrobe) && wakeAny) |=> (state == ST_RUN)); // R10
  AST_DEEP_STEPS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAKE_PF) |=> (state == ST_WAKE_SYS)); // R7
  AST_ASLEEP_IGNORES: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLP_DEEP && !wakeAny) |=> (state == ST_SLP_DEEP)); // R13

endmodule

// File: rtl/sleep_gate_dp.sv
`timescale 1ns/1ps
module sleep_gate_dp
  import sleep_gate_pkg::*;
#(
  parameter bit WAKE_SETS_EVENT = 1'b1
) (
  input  logic      clk,
  input  logic      rstN,
  input  gateCtrl_t ctrl,
  input  logic      eventSet,
  input  logic      wakeReq,
  output logic      evtFlag,
  output logic      procEn,
  output logic      sysEn,
  output logic      pllOn,
  output logic      flashOn,
  output logic      resumeQ
);

  logic evtSetIn;

  generate
    if (WAKE_SETS_EVENT) begin : g_wakeSets
      assign evtSetIn = eventSet || wakeReq;
    end else begin : g_eventOnly
      assign evtSetIn = eventSet;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtFlag <= 1'b0;
      procEn  <= 1'b1;
      sysEn   <= 1'b1;
      pllOn   <= 1'b1;
      flashOn <= 1'b1;
      resumeQ <= 1'b0;
    end else begin
      if (evtSetIn)           evtFlag <= 1'b1;   // set beats clear
      else if (ctrl.evtClear) evtFlag <= 1'b0;

      if (ctrl.gateProc || ctrl.gateDeep) procEn <= 1'b0;
      else if (ctrl.restoreProc)          procEn <= 1'b1;

      if (ctrl.gateDeep)        sysEn <= 1'b0;
      else if (ctrl.restoreSys) sysEn <= 1'b1;

      if (ctrl.gateDeep) begin
        pllOn   <= 1'b0;
        flashOn <= 1'b0;
      end else if (ctrl.restorePf) begin
        pllOn   <= 1'b1;
        flashOn <= 1'b1;
      end

      resumeQ <= ctrl.resume;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    evtSetIn |=> evtFlag); // R4
  AST_SYS_BEFORE_PROC: assert property (@(posedge clk) disable iff (!rstN)
    $rose(procEn) |-> sysEn); // R7
  AST_PF_BEFORE_SYS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysEn) |-> (pllOn && flashOn)); // R7

endmodule

// File: rtl/sleep_gate_ctrl.sv
`timescale 1ns/1ps
module sleep_gate_ctrl
  import sleep_gate_pkg::*;
#(
  parameter bit WAKE_SETS_EVENT = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic wfiStrobe,
  input  logic wfeStrobe,
  input  logic eventSet,
  input  logic deepSel,
  input  logic wakeReq,
  input  logic debugReq,
  output logic procClkEn,
  output logic sysClkEn,
  output logic pllEn,
  output logic flashEn,
  output logic sleeping,
  output logic resumeOut
);

  gateCtrl_t ctrl;
  logic      evtFlag;
  logic      wakeAny;

  assign wakeAny = wakeReq || debugReq || eventSet;

  sleep_gate_fsm u_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .wfiStrobe (wfiStrobe),
    .wfeStrobe (wfeStrobe),
    .deepSel   (deepSel),
    .wakeAny   (wakeAny),
    .evtFlag   (evtFlag),
    .ctrl      (ctrl)
  );

  sleep_gate_dp #(.WAKE_SETS_EVENT(WAKE_SETS_EVENT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .eventSet (eventSet),
    .wakeReq  (wakeReq),
    .evtFlag  (evtFlag),
    .procEn   (procClkEn),
    .sysEn    (sysClkEn),
    .pllOn    (pllEn),
    .flashOn  (flashEn),
    .resumeQ  (resumeOut)
  );

  assign sleeping = !procClkEn;

  AST_RESUME_AWAKE: assert property (@(posedge clk) disable iff (!rstN)
    resumeOut |-> procClkEn); // R12
  AST_LIGHT_KEEPS_PF: assert property (@(posedge clk) disable iff (!rstN)
    (!procClkEn && sysClkEn) |-> (pllEn && flashEn)); // R5

endmodule

// File: tb/sleep_gate_ctrl_bench.sv
`timescale 1ns/1ps
module sleep_gate_ctrl_bench;

  logic clk = 1'b0;
  logic rstN;
  logic wfiStrobe, wfeStrobe, eventSet, deepSel, wakeReq, debugReq;
  logic procClkEn, sysClkEn, pllEn, flashEn, sleeping, resumeOut;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // reference model: 0 run, 1 light, 2 deep, 3 pll/flash up, 4 sys up
  int   mState;
  logic mEvt;
  logic mRes;

  always #2 clk = ~clk;

  sleep_gate_ctrl u_sleep_gate_ctrl (
    .clk(clk), .rstN(rstN), .wfiStrobe(wfiStrobe), .wfeStrobe(wfeStrobe),
    .eventSet(eventSet), .deepSel(deepSel), .wakeReq(wakeReq), .debugReq(debugReq),
    .procClkEn(procClkEn), .sysClkEn(sysClkEn), .pllEn(pllEn), .flashEn(flashEn),
    .sleeping(sleeping), .resumeOut(resumeOut)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic expProc(int st); return st == 0; endfunction
  function automatic logic expSys(int st);  return st == 0 || st == 1 || st == 4; endfunction
  function automatic logic expPf(int st);   return st != 2; endfunction

  task automatic modelStep(input logic wfi, input logic wfe, input logic es,
                           input logic deep, input logic wk, input logic dbg);
    logic wakeAny, enter, clr;
    wakeAny = wk | dbg | es;
    clr  = 1'b0;
    mRes = 1'b0;
    case (mState)
      0: begin
        enter = wfi | (wfe & ~mEvt);
        if (enter && wakeAny) mRes = 1'b1;
        else if (enter) mState = deep ? 2 : 1;
        else if (wfe && mEvt) begin clr = 1'b1; mRes = 1'b1; end
      end
      1: if (wakeAny) begin mState = 0; mRes = 1'b1; end
      2: if (wakeAny) mState = 3;
      3: mState = 4;
      default: begin mState = 0; mRes = 1'b1; end
    endcase
    if (es || wk) mEvt = 1'b1;
    else if (clr) mEvt = 1'b0;
  endtask

  task automatic compareAll();
    chk("R1 procClkEn", procClkEn, expProc(mState));
    chk("R6 sysClkEn", sysClkEn, expSys(mState));
    chk("R7 pllEn", pllEn, expPf(mState));
    chk("R7 flashEn", flashEn, expPf(mState));
    chk("R9 sleeping", sleeping, ~expProc(mState));
    chk("R12 resumeOut", resumeOut, mRes);
  endtask

  // one cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input logic wfi, input logic wfe, input logic es,
                     input logic deep, input logic wk, input logic dbg);
    wfiStrobe = wfi; wfeStrobe = wfe; eventSet = es;
    deepSel = deep; wakeReq = wk; debugReq = dbg;
    @(posedge clk);
    modelStep(wfi, wfe, es, deep, wk, dbg);
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 0, 0); endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0;
    wfiStrobe = 0; wfeStrobe = 0; eventSet = 0; deepSel = 0; wakeReq = 0; debugReq = 0;
    mState = 0; mEvt = 1'b0; mRes = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // reset state
    chk("R9 reset sleeping", sleeping, 1'b0);
    chk("R5 reset sysClkEn", sysClkEn, 1'b1);
    chk("R7 reset pllEn", pllEn, 1'b1);
    chk("R12 reset resumeOut", resumeOut, 1'b0);

    // R2: wfe with flag clear after reset, light depth
    cyc(0, 1, 0, 0, 0, 0);
    chk("R2 wfe sleeps", procClkEn, 1'b0);
    chk("R5 light keeps sys", sysClkEn, 1'b1);
    chk("R5 light keeps pll", pllEn, 1'b1);
    chk("R9 sleeping while gated", sleeping, 1'b1);
    // R13: strobes while asleep ignored
    cyc(1, 0, 0, 1, 0, 0);
    cyc(0, 1, 0, 1, 0, 0);
    chk("R13 strobe ignored proc", procClkEn, 1'b0);
    chk("R13 strobe ignored sys", sysClkEn, 1'b1);
    // R8: debug wake from light sleep
    cyc(0, 0, 0, 0, 0, 1);
    chk("R8 proc restored", procClkEn, 1'b1);
    chk("R12 resume pulse", resumeOut, 1'b1);
    idle();
    chk("R12 resume single cycle", resumeOut, 1'b0);
    // R11: debug did not set flag
    cyc(0, 1, 0, 0, 0, 0);
    chk("R11 wfe re-enters sleep", procClkEn, 1'b0);
    // wakeReq wake sets the flag (R4), then wfe continues (R3)
    cyc(0, 0, 0, 0, 1, 0);
    chk("R8 wakeReq wake", procClkEn, 1'b1);
    idle();
    cyc(0, 1, 0, 0, 0, 0);
    chk("R3 wfe continues", procClkEn, 1'b1);
    chk("R3 continue pulse", resumeOut, 1'b1);
    cyc(0, 1, 0, 0, 0, 0);
    chk("R3 flag consumed", procClkEn, 1'b0);
    cyc(0, 0, 0, 0, 0, 1);
    idle();
    // R4: set wins over consume
    cyc(0, 0, 1, 0, 0, 0);
    cyc(0, 1, 1, 0, 0, 0);
    chk("R4 no sleep on set+wfe", procClkEn, 1'b1);
    cyc(0, 1, 0, 0, 0, 0);
    chk("R4 flag survived", procClkEn, 1'b1);
    chk("R4 continue again", resumeOut, 1'b1);
    cyc(0, 1, 0, 0, 0, 0);
    chk("R4 then sleeps", procClkEn, 1'b0);
    cyc(0, 0, 0, 0, 0, 1);
    idle();
    // R6/R7: deep entry and staged wake
    cyc(1, 0, 0, 1, 0, 0);
    chk("R1 wfi sleeps", procClkEn, 1'b0);
    chk("R6 sys off", sysClkEn, 1'b0);
    chk("R6 pll off", pllEn, 1'b0);
    chk("R6 flash off", flashEn, 1'b0);
    idle();
    cyc(0, 0, 0, 0, 0, 1);
    chk("R7 pll first", pllEn, 1'b1);
    chk("R7 flash first", flashEn, 1'b1);
    chk("R7 sys not yet", sysClkEn, 1'b0);
    idle();
    chk("R7 sys second", sysClkEn, 1'b1);
    chk("R7 proc not yet", procClkEn, 1'b0);
    idle();
    chk("R7 proc third", procClkEn, 1'b1);
    chk("R12 resume after deep", resumeOut, 1'b1);
    // R10: abort on simultaneous wake
    cyc(1, 0, 0, 0, 1, 0);
    chk("R10 abort light proc", procClkEn, 1'b1);
    chk("R10 abort resume", resumeOut, 1'b1);
    cyc(1, 0, 0, 1, 0, 1);
    chk("R10 abort deep sys", sysClkEn, 1'b1);
    chk("R10 abort deep pll", pllEn, 1'b1);
    idle();

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 16) == 0, ($urandom % 12) == 0, ($urandom % 24) == 0,
          $urandom % 2, ($urandom % 20) == 0, ($urandom % 28) == 0);
    end
    repeat (4) idle();

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule